// File: doc/BRIEF.md
# Chainable Serial Command Register for a Two-Channel Resistor Controller

This block is the serial front end of a two-channel programmable resistor controller. A host sends 24-bit words over a four-wire SPI link. Each word carries a 4-bit operation code in its top bits, a 4-bit address below that, and a 16-bit data field at the bottom, sent most significant bit first. The block keeps two 10-bit wiper settings and a 16-word by 16-bit register file that stands in for non-volatile storage. It acts on the captured word only when chip select returns high.

The serial register also serves as a pass-through stage. The bit that leaves its top end drives the serial output, so several devices can be wired output-to-input and fed in one long chip-select frame. Each device then executes the last 24 bits it holds. A read operation places the requested value in the low 16 bits of the serial register when chip select is released. The next frame clocks that value out.

SPI signals are sampled on the block clock through a synchronizer. They are therefore expected to toggle well below the clock rate.

Top module: `daisy_cmd_reg`

## Requirements
- R1: A word is captured MSB first on rising serial-clock edges while chip select is low, and it is acted on only after chip select goes high; bits [23:20] are the code, [19:16] the address, [15:0] the data.
- R2: After reset both wipers hold mid-scale (0x200), every register-file word reads as zero, and the serial output is not driven.
- R3: Code 11 copies data bits [9:0] into wiper 1 when address bit 0 is 0, and into wiper 2 when it is 1; data bits [15:10] and address bits [3:1] have no effect.
- R4: Code 3 writes all 16 data bits to the register-file word selected by the 4-bit address.
- R5: A code-3 write to address 15 is dropped, and that word keeps reading zero.
- R6: Code 0, and every code other than 0, 3, 9, 10 and 11, leaves the wipers and the register file unchanged.
- R7: A frame with fewer than 24 rising serial-clock edges is discarded without any effect.
- R8: In a frame longer than 24 bits, the last 24 bits received are executed. Each bit appears on the serial output 24 clock edges after it entered, so in a 48-bit frame the first 24 bits emerge in order during the second half.
- R9: Code 9 (register-file word at the address) and code 10 (wiper chosen by address bit 0, zero-extended to 16 bits) load the value into data bits [15:0] of the serial register. Code and address are kept, and the next frame shifts out the whole 24-bit word MSB first.
- R10: The serial output enable is high while chip select is low and is released within a few clock cycles after chip select goes high.
- R11: SPI mode 0 (clock idles low) and mode 3 (clock idles high) both capture the same words: input is sampled on the rising edge and the output changes on the falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sdi | input | 1 | Serial data in |
| sdo_oe | output | 1 | Output driver enable for the open-drain serial output |
| sdo_dat | output | 1 | Serial data out; a 0 with enable set pulls the line low |
| wiper1 | output | 10 | First wiper setting |
| wiper2 | output | 10 | Second wiper setting |

## Verification
The checker assumes that the serial clock and chip select change slowly compared with the block clock. Every edge must survive the synchronizer before the next one arrives, and chip select must stay high long enough for the frame to execute. The bench holds each serial-clock phase for six block cycles. It waits twelve cycles after each release of chip select before sampling. It changes the data line only during the low phase of the serial clock. With this pacing, the window in which the output must be released and the one-cycle link from an executed frame to the wiper value both hold. Faster stimulus would break these properties.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
   localparam int OP_W = 4;

   typedef enum logic [OP_W-1:0] {
      OP_IDLE    = 4'd0,
      OP_MEM_WR  = 4'd3,
      OP_MEM_RD  = 4'd9,
      OP_WIP_RD  = 4'd10,
      OP_WIP_WR  = 4'd11
   } op_e;
endpackage

// File: rtl/dcr_sync.sv
module dcr_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= {STAGES{RST_VAL}};
      else        pipe <= {pipe[STAGES-2:0], d};
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/dcr_shifter.sv
module dcr_shifter #(
   parameter int FRAME_W     = 24,
   parameter int DATA_W      = 16,
   parameter int SYNC_STAGES = 2,
   localparam int CNT_W      = $clog2(FRAME_W + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sclk,
   input  logic               cs_n,
   input  logic               sdi,
   input  logic               ld_en,
   input  logic [DATA_W-1:0]  ld_data,
   output logic [FRAME_W-1:0] frame,
   output logic               go,
   output logic               sel,
   output logic               out_bit,
   output logic [CNT_W-1:0]   bit_cnt
);
   logic sclk_s, cs_s, sdi_s;
   logic sclk_d, cs_d;
   logic sck_rise, sck_fall, cs_rise, cs_fall;

   dcr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sck (
      .clk(clk), .rst_n(rst_n), .d(sclk), .q(sclk_s));
   dcr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
      .clk(clk), .rst_n(rst_n), .d(cs_n), .q(cs_s));
   dcr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sdi (
      .clk(clk), .rst_n(rst_n), .d(sdi), .q(sdi_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d <= 1'b0;
         cs_d   <= 1'b1;
      end else begin
         sclk_d <= sclk_s;
         cs_d   <= cs_s;
      end
   end

   assign sck_rise = sclk_s & ~sclk_d;
   assign sck_fall = ~sclk_s & sclk_d;
   assign cs_rise  = cs_s & ~cs_d;
   assign cs_fall  = ~cs_s & cs_d;
   assign sel      = ~cs_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame   <= '0;
         bit_cnt <= '0;
         go      <= 1'b0;
         out_bit <= 1'b0;
      end else begin
         go <= cs_rise && (bit_cnt == CNT_W'(FRAME_W));
         if (cs_fall) begin
            bit_cnt <= '0;
         end else if (sel && sck_rise) begin
            frame <= {frame[FRAME_W-2:0], sdi_s};
            if (bit_cnt != CNT_W'(FRAME_W)) bit_cnt <= bit_cnt + 1'b1;
         end
         if (ld_en) frame[DATA_W-1:0] <= ld_data;
         if (!sel || sck_fall) out_bit <= frame[FRAME_W-1];
      end
   end
endmodule

// File: rtl/dcr_exec.sv
module dcr_exec
   import dcr_pkg::*;
#(
   parameter int ADDR_W  = 4,
   parameter int DATA_W  = 16,
   parameter int WIPER_W = 10,
   localparam int DEPTH  = 1 << ADDR_W,
   localparam int RSV    = DEPTH - 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               go,
   input  logic [OP_W-1:0]    op,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [DATA_W-1:0]  data,
   output logic [WIPER_W-1:0] wiper1,
   output logic [WIPER_W-1:0] wiper2,
   output logic               wr_wip,
   output logic               wr_mem,
   output logic               ld_en,
   output logic [DATA_W-1:0]  ld_data
);
   localparam logic [WIPER_W-1:0] MID = WIPER_W'(1) << (WIPER_W - 1);

   logic                rd_wip, rd_mem;
   logic [WIPER_W-1:0]  wip [2];
   logic [DATA_W-1:0]   mem [DEPTH];

   always_comb begin
      wr_wip = 1'b0;
      wr_mem = 1'b0;
      rd_wip = 1'b0;
      rd_mem = 1'b0;
      if (go) begin
         case (op)
            OP_WIP_WR: wr_wip = 1'b1;
            OP_MEM_WR: wr_mem = (addr != ADDR_W'(RSV));
            OP_WIP_RD: rd_wip = 1'b1;
            OP_MEM_RD: rd_mem = 1'b1;
            default:   ;
         endcase
      end
   end

   generate
      for (genvar w = 0; w < 2; w++) begin : g_wip
         localparam logic SEL = (w == 1);
         logic [WIPER_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        q <= MID;
            else if (wr_wip && addr[0] == SEL) q <= data[WIPER_W-1:0];
         end
         assign wip[w] = q;
      end

      for (genvar e = 0; e < DEPTH; e++) begin : g_mem
         if (e == RSV) begin : g_rsv
            assign mem[e] = '0;
         end else begin : g_word
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)                             q <= '0;
               else if (wr_mem && addr == ADDR_W'(e)) q <= data;
            end
            assign mem[e] = q;
         end
      end
   endgenerate

   assign wiper1  = wip[0];
   assign wiper2  = wip[1];
   assign ld_en   = rd_wip | rd_mem;
   assign ld_data = rd_wip ? {{(DATA_W-WIPER_W){1'b0}}, wip[addr[0]]} : mem[addr];
endmodule

// File: rtl/daisy_cmd_reg.sv
module daisy_cmd_reg
   import dcr_pkg::*;
#(
   parameter int ADDR_W      = 4,
   parameter int DATA_W      = 16,
   parameter int WIPER_W     = 10,
   parameter int SYNC_STAGES = 2,
   localparam int FRAME_W    = OP_W + ADDR_W + DATA_W,
   localparam int CNT_W      = $clog2(FRAME_W + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               spi_sclk,
   input  logic               spi_cs_n,
   input  logic               spi_sdi,
   output logic               sdo_oe,
   output logic               sdo_dat,
   output logic [WIPER_W-1:0] wiper1,
   output logic [WIPER_W-1:0] wiper2
);
   generate
      if (WIPER_W > DATA_W) begin : g_bad_wiper
         $error("wiper wider than data field");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("synchronizer needs two or more stages");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("address field must be non-empty");
      end
   endgenerate

   logic [FRAME_W-1:0] frame;
   logic               go, sel, out_bit;
   logic [CNT_W-1:0]   bit_cnt;
   logic               wr_wip, wr_mem, ld_en;
   logic [DATA_W-1:0]  ld_data;

   dcr_shifter #(.FRAME_W(FRAME_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_shift (
      .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n), .sdi(spi_sdi),
      .ld_en(ld_en), .ld_data(ld_data), .frame(frame), .go(go), .sel(sel),
      .out_bit(out_bit), .bit_cnt(bit_cnt));

   dcr_exec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIPER_W(WIPER_W)) u_exec (
      .clk(clk), .rst_n(rst_n), .go(go),
      .op(frame[FRAME_W-1 -: OP_W]),
      .addr(frame[DATA_W +: ADDR_W]),
      .data(frame[DATA_W-1:0]),
      .wiper1(wiper1), .wiper2(wiper2),
      .wr_wip(wr_wip), .wr_mem(wr_mem), .ld_en(ld_en), .ld_data(ld_data));

   assign sdo_oe  = sel;
   assign sdo_dat = out_bit;
endmodule

// File: rtl/daisy_cmd_reg_chk.sv
module daisy_cmd_reg_chk
   import dcr_pkg::*;
#(
   parameter int FRAME_W     = 24,
   parameter int DATA_W      = 16,
   parameter int WIPER_W     = 10,
   parameter int SYNC_STAGES = 2,
   parameter int CNT_W       = 5
) (
   input logic               clk,
   input logic               rst_n,
   input logic               spi_cs_n,
   input logic               sdo_oe,
   input logic               go,
   input logic [FRAME_W-1:0] frame,
   input logic [CNT_W-1:0]   bit_cnt,
   input logic [WIPER_W-1:0] wiper1,
   input logic [WIPER_W-1:0] wiper2,
   input logic               wr_wip,
   input logic               wr_mem,
   input logic               ld_en
);
   localparam int HI_W   = $clog2(SYNC_STAGES + 4) + 1;
   localparam int HI_MAX = SYNC_STAGES + 3;

   logic [HI_W-1:0] hi_cnt;
   logic [OP_W-1:0] op;
   logic            asel;

   assign op   = frame[FRAME_W-1 -: OP_W];
   assign asel = frame[DATA_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        hi_cnt <= '0;
      else if (!spi_cs_n)                hi_cnt <= '0;
      else if (hi_cnt != HI_W'(HI_MAX))  hi_cnt <= hi_cnt + 1'b1;
   end

   p_full_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> bit_cnt == CNT_W'(FRAME_W));

   p_wiper1_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (go && op == OP_WIP_WR && !asel) |=> wiper1 == $past(frame[WIPER_W-1:0]));

   p_wiper2_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (go && op == OP_WIP_WR && asel) |=> wiper2 == $past(frame[WIPER_W-1:0]));

   p_hold_wipers_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(go && op == OP_WIP_WR) |=> ($stable(wiper1) && $stable(wiper2)));

   p_sdo_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_cnt > HI_W'(SYNC_STAGES + 1)) |-> !sdo_oe);

   p_one_action_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_wip, wr_mem, ld_en}));
endmodule

bind daisy_cmd_reg daisy_cmd_reg_chk #(
   .FRAME_W(FRAME_W), .DATA_W(DATA_W), .WIPER_W(WIPER_W),
   .SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .sdo_oe(sdo_oe),
   .go(go), .frame(frame), .bit_cnt(bit_cnt), .wiper1(wiper1), .wiper2(wiper2),
   .wr_wip(wr_wip), .wr_mem(wr_mem), .ld_en(ld_en));

// File: tb/daisy_cmd_reg_tb.sv
`timescale 1ns/1ps
module daisy_cmd_reg_tb;
   localparam int HALF = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sclk = 1'b0;
   logic       cs_n = 1'b1;
   logic       sdi = 1'b0;
   logic       sdo_oe, sdo_dat;
   logic [9:0] wiper1, wiper2;

   int         n_chk = 0;
   int         n_bad = 0;
   logic [47:0] cap;
   logic        oe_mid;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   daisy_cmd_reg u_dut (
      .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_sdi(sdi),
      .sdo_oe(sdo_oe), .sdo_dat(sdo_dat), .wiper1(wiper1), .wiper2(wiper2));

   // frame, expected wiper1, expected wiper2
   localparam logic [43:0] VECS [6] = '{
      {24'hB00155, 10'h155, 10'h200},
      {24'hB103FF, 10'h155, 10'h3FF},
      {24'hB0FC2A, 10'h02A, 10'h3FF},
      {24'h000000, 10'h02A, 10'h3FF},
      {24'h710111, 10'h02A, 10'h3FF},
      {24'hB30001, 10'h02A, 10'h001}
   };

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic xfer(input logic [47:0] bits, input int n, input bit mode3);
      cap = '0;
      sclk = mode3;
      wait_clk(HALF);
      cs_n = 1'b0;
      wait_clk(HALF);
      for (int i = 0; i < n; i++) begin
         sclk = 1'b0;
         sdi = bits[n-1-i];
         wait_clk(HALF);
         cap[n-1-i] = sdo_dat;
         if (i == 0) oe_mid = sdo_oe;
         sclk = 1'b1;
         wait_clk(HALF);
      end
      if (!mode3) begin
         sclk = 1'b0;
         wait_clk(HALF);
      end
      cs_n = 1'b1;
      wait_clk(12);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog act=running exp=finished");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(5);

      // R2: reset state
      chk("R2 wiper1 reset", 48'(wiper1), 48'h200);
      chk("R2 wiper2 reset", 48'(wiper2), 48'h200);
      chk("R2 sdo released", 48'(sdo_oe), 48'h0);

      // R1 R3 R6 R11: vector walk, odd entries in mode 3
      for (int k = 0; k < 6; k++) begin
         xfer(48'(VECS[k][43:20]), 24, k[0]);
         chk("R1 R3 R6 R11 wiper1", 48'(wiper1), 48'(VECS[k][19:10]));
         chk("R1 R3 R6 R11 wiper2", 48'(wiper2), 48'(VECS[k][9:0]));
      end

      // R4 R9: register-file write, read, shift out
      xfer(48'h36BEEF, 24, 1'b0);
      xfer(48'h960000, 24, 1'b1);
      xfer(48'h000000, 24, 1'b0);
      chk("R4 R9 memory readback", cap[23:0], 48'h96BEEF);

      // R9: wiper 2 readback zero-extended
      xfer(48'hA10000, 24, 1'b0);
      xfer(48'h000000, 24, 1'b1);
      chk("R9 wiper readback", cap[23:0], 48'hA10001);

      // R5: reserved address write dropped
      xfer(48'h3F1234, 24, 1'b0);
      xfer(48'h9F0000, 24, 1'b0);
      xfer(48'h000000, 24, 1'b0);
      chk("R5 reserved word", cap[23:0], 48'h9F0000);

      // R6 R2: unlisted code 2 does not write word 5, which is still zero
      xfer(48'h250777, 24, 1'b1);
      xfer(48'h950000, 24, 1'b0);
      xfer(48'h000000, 24, 1'b0);
      chk("R6 R2 word 5 untouched", cap[23:0], 48'h950000);

      // R7: short frame discarded
      xfer(48'h0B0033, 20, 1'b0);
      chk("R7 short frame wiper1", 48'(wiper1), 48'h02A);
      chk("R7 short frame wiper2", 48'(wiper2), 48'h001);

      // R8: 48-bit chained frame
      xfer({24'hB10077, 24'hB00099}, 48, 1'b1);
      chk("R8 last 24 bits executed", 48'(wiper1), 48'h099);
      chk("R8 first word untouched wiper2", 48'(wiper2), 48'h001);
      chk("R8 pass-through bits", cap[23:0], 48'hB10077);

      // R10: output enable during and after a frame
      xfer(48'h000000, 24, 1'b0);
      chk("R10 enable during frame", 48'(oe_mid), 48'h1);
      chk("R10 released after frame", 48'(sdo_oe), 48'h0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule